// File: doc/BRIEF.md
# Extended-Register Operand Adder

This block is the integer add and subtract datapath for the extended-register operand form. The second operand is taken from a register value, and the lowest byte, halfword, word or doubleword of it is zero- or sign-extended. That value is shifted left by zero to four places and then added to, or subtracted from, the first operand. The operation runs at either 32 or 64 bits. The block returns the result, the four condition flags (negative, zero, carry, overflow) and an indication that the encoding is illegal.

Register index 31 is resolved inside the block. On the first source it selects the stack pointer value. On the second source it reads as zero. On the destination it raises a stack-pointer write indication. The extension length is limited to the operand size minus the shift amount, which is why word and doubleword extension give the same result on 32-bit operations.

The inputs are sampled on every rising clock edge, and the outputs are registered, so each result appears one cycle after its inputs. The condition flags are held in a register that changes only when flag setting is requested.

Top module: `ext_reg_adder`

## Requirements
- R1: The two low bits of `ext_opt` select the width of the slice of the second operand that is extended: 0 = 8 bits, 1 = 16 bits, 2 = 32 bits, 3 = 64 bits. For codes 0 to 2, bit 2 of `ext_opt` selects the extension: 0 = zero-extend, 1 = sign-extend.
- R2: Width code 3 applies no extension for either value of `ext_opt[2]`.
- R3: The extended value is shifted left by `shamt` (0 to 4) before the add or subtract.
- R4: On a 32-bit operation, `ext_opt` values 2, 3, 6 and 7 with a shift of 3 give the same result and flags as adding the second operand shifted left by 3, because the extension length is min(width, datasize minus shift).
- R5: A `shamt` of 5 to 7 sets `illegal` and forces both `result` and `nzcv` to zero, whatever the value of `set_flags`.
- R6: When `wide`=0, the low 32 bits of `result` are computed and bits 63:32 are zero. N is taken from bit 31, and carry and overflow come from the 32-bit add.
- R7: Subtraction computes first operand + ~operand + 1. C is 1 when there is no borrow (first operand >= second operand, unsigned). V is set on signed overflow.
- R8: `nzcv` is written only when `set_flags`=1. Otherwise it keeps its value (except as stated in R5). The bit order is [3]=N, [2]=Z, [1]=C, [0]=V.
- R9: An index of 31 selects `sp_val` on the first source and zero on the second source. `rd_idx`=31 sets `wr_sp`, and any other `rd_idx` clears it.
- R10: While `rst` is high, `result`, `nzcv`, `wr_sp` and `illegal` are zero.
- R11: Outputs change only at a rising clock edge and reflect the inputs sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rn_idx | input | 5 | Index of the first source register |
| rn_val | input | 64 | Value of the first source register |
| sp_val | input | 64 | Stack pointer value |
| rm_idx | input | 5 | Index of the second source register |
| rm_val | input | 64 | Value of the second source register |
| rd_idx | input | 5 | Index of the destination register |
| ext_opt | input | 3 | Extension option: [1:0] width, [2] sign |
| shamt | input | 3 | Left shift amount |
| wide | input | 1 | 1 = 64-bit operation, 0 = 32-bit operation |
| is_sub | input | 1 | 1 = subtract, 0 = add |
| set_flags | input | 1 | Enables the flag update |
| result | output | 64 | Registered result |
| nzcv | output | 4 | Registered flags N, Z, C, V |
| wr_sp | output | 1 | Destination is the stack pointer |
| illegal | output | 1 | Shift amount is out of range |

## Verification
An illegal shift and a flag-setting request can occur in the same cycle. In that cycle the illegal clear must win over the new flag value, and in the next legal cycle with `set_flags` low the flags must stay at the cleared value. The bench sweeps every option, shift, width and add or subtract combination with flag setting toggling, so this overlap occurs many times. After each cycle it compares `nzcv` with a flag model that updates only under the rules of R5 and R8. The clipped extension and the doubleword no-extension case are judged against a plain byte-slice extension model computed separately in the bench.

// File: rtl/xra_pkg.sv
package xra_pkg;
  typedef enum logic [1:0] {
    EW_BYTE  = 2'd0,
    EW_HALF  = 2'd1,
    EW_WORD  = 2'd2,
    EW_DWORD = 2'd3
  } ext_width_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;
endpackage

// File: rtl/xra_operand.sv
module xra_operand #(
  parameter int XLEN  = 64,
  parameter int SHW   = 3,
  parameter int MAXSH = 4
) (
  input  logic [XLEN-1:0] src,
  input  logic [2:0]      opt,
  input  logic [SHW-1:0]  sh,
  input  logic            wide,
  output logic [XLEN-1:0] opnd
);
  import xra_pkg::*;

  localparam int LW = $clog2(XLEN + 1);
  localparam int HALF = XLEN / 2;
  localparam logic [XLEN-1:0] ONE = {{(XLEN-1){1'b0}}, 1'b1};
  localparam logic [XLEN-1:0] LOWMASK = {{HALF{1'b0}}, {HALF{1'b1}}};

  logic [LW-1:0] wtab [4];

  genvar g;
  generate
    for (g = 0; g < 4; g++) begin : g_wtab
      if (g == 3) begin : g_full
        assign wtab[g] = LW'(XLEN);
      end else begin : g_part
        assign wtab[g] = LW'(8 << g);
      end
    end
  endgenerate

  ext_width_e    wsel;
  logic [LW-1:0] ds, room, wbits, len;
  logic [XLEN-1:0] mask, field, shifted;

  always_comb begin
    wsel  = ext_width_e'(opt[1:0]);
    wbits = wtab[wsel];
    ds    = wide ? LW'(XLEN) : LW'(HALF);
    room  = ds - LW'(sh);
    len   = (wbits < room) ? wbits : room;
    mask  = (len >= LW'(XLEN)) ? '1 : ((ONE << len) - ONE);
    field = src & mask;
    if (opt[2] && src[len - LW'(1)]) begin
      field = field | ~mask;
    end
    shifted = field << sh;
    opnd    = wide ? shifted : (shifted & LOWMASK);
  end

  always_comb begin
    // R3
    if (sh <= SHW'(MAXSH)) begin
      low_bits_chk: assert ((opnd & ((ONE << sh) - ONE)) == '0);
    end
    // R2
    if (opt[1:0] == 2'b11 && sh == '0) begin
      dword_pass_chk: assert (opnd == (wide ? src : (src & LOWMASK)));
    end
  end
endmodule

// File: rtl/xra_alu.sv
module xra_alu #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0]  a,
  input  logic [XLEN-1:0]  b,
  input  logic             wide,
  input  logic             sub,
  output logic [XLEN-1:0]  res,
  output xra_pkg::nzcv_t   flags
);
  localparam int HALF = XLEN / 2;

  logic [XLEN-1:0] bb;
  logic [XLEN:0]   full;
  logic [HALF:0]   part;

  always_comb begin
    bb   = sub ? ~b : b;
    full = {1'b0, a} + {1'b0, bb} + {{XLEN{1'b0}}, sub};
    part = {1'b0, a[HALF-1:0]} + {1'b0, bb[HALF-1:0]} + {{HALF{1'b0}}, sub};
    if (wide) begin
      res     = full[XLEN-1:0];
      flags.n = res[XLEN-1];
      flags.c = full[XLEN];
      flags.v = (a[XLEN-1] == bb[XLEN-1]) && (res[XLEN-1] != a[XLEN-1]);
    end else begin
      res     = {{HALF{1'b0}}, part[HALF-1:0]};
      flags.n = part[HALF-1];
      flags.c = part[HALF];
      flags.v = (a[HALF-1] == bb[HALF-1]) && (part[HALF-1] != a[HALF-1]);
    end
    flags.z = (res == '0);
  end

  always_comb begin
    // R7
    if (wide && !sub) begin
      add_carry_chk: assert (flags.c == (res < a));
    end
  end
endmodule

// File: rtl/ext_reg_adder.sv
module ext_reg_adder #(
  parameter int XLEN  = 64,
  parameter int REGW  = 5,
  parameter int SHW   = 3,
  parameter int MAXSH = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [REGW-1:0] rn_idx,
  input  logic [XLEN-1:0] rn_val,
  input  logic [XLEN-1:0] sp_val,
  input  logic [REGW-1:0] rm_idx,
  input  logic [XLEN-1:0] rm_val,
  input  logic [REGW-1:0] rd_idx,
  input  logic [2:0]      ext_opt,
  input  logic [SHW-1:0]  shamt,
  input  logic            wide,
  input  logic            is_sub,
  input  logic            set_flags,
  output logic [XLEN-1:0] result,
  output logic [3:0]      nzcv,
  output logic            wr_sp,
  output logic            illegal
);
  import xra_pkg::*;

  localparam logic [REGW-1:0] IDX31 = '1;
  localparam int HALF = XLEN / 2;

  logic [XLEN-1:0] op_a, rm_src, op_b, sum;
  nzcv_t           fl;
  logic            bad_sh;

  assign op_a   = (rn_idx == IDX31) ? sp_val : rn_val;
  assign rm_src = (rm_idx == IDX31) ? '0 : rm_val;
  assign bad_sh = (shamt > SHW'(MAXSH));

  xra_operand #(.XLEN(XLEN), .SHW(SHW), .MAXSH(MAXSH)) u_opnd (
    .src  (rm_src),
    .opt  (ext_opt),
    .sh   (shamt),
    .wide (wide),
    .opnd (op_b)
  );

  xra_alu #(.XLEN(XLEN)) u_alu (
    .a     (op_a),
    .b     (op_b),
    .wide  (wide),
    .sub   (is_sub),
    .res   (sum),
    .flags (fl)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result  <= '0;
      nzcv    <= '0;
      wr_sp   <= 1'b0;
      illegal <= 1'b0;
    end else begin
      illegal <= bad_sh;
      wr_sp   <= (rd_idx == IDX31);
      result  <= bad_sh ? '0 : sum;
      if (bad_sh) begin
        nzcv <= '0;
      end else if (set_flags) begin
        nzcv <= fl;
      end
    end
  end

  // R5
  illegal_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (shamt > SHW'(MAXSH)) |=> (illegal && result == '0 && nzcv == 4'd0));

  // R8
  flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!set_flags && shamt <= SHW'(MAXSH)) |=> $stable(nzcv));

  // R6
  narrow_upper_chk: assert property (@(posedge clk) disable iff (rst)
    !wide |=> (result[XLEN-1:HALF] == '0));
endmodule

// File: tb/sim_ext_reg_adder.sv
module sim_ext_reg_adder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  rn_idx = 5'd3, rm_idx = 5'd4, rd_idx = 5'd7;
  logic [63:0] rn_val = '0, sp_val = '0, rm_val = '0;
  logic [2:0]  ext_opt = '0, shamt = '0;
  logic        wide = 1'b1, is_sub = 1'b0, set_flags = 1'b0;
  logic [63:0] result;
  logic [3:0]  nzcv;
  logic        wr_sp, illegal;

  int errors = 0;
  int checks = 0;
  logic [3:0] exp_fl = '0;
  bit done = 0;

  always #5 clk = ~clk;

  ext_reg_adder u0 (
    .clk(clk), .rst(rst), .rn_idx(rn_idx), .rn_val(rn_val), .sp_val(sp_val),
    .rm_idx(rm_idx), .rm_val(rm_val), .rd_idx(rd_idx), .ext_opt(ext_opt),
    .shamt(shamt), .wide(wide), .is_sub(is_sub), .set_flags(set_flags),
    .result(result), .nzcv(nzcv), .wr_sp(wr_sp), .illegal(illegal)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] ext_model(input logic [63:0] v, input logic [2:0] o,
                                            input logic [2:0] s, input logic w);
    logic [63:0] e;
    case (o[1:0])
      2'd0: e = o[2] ? {{56{v[7]}}, v[7:0]} : {56'b0, v[7:0]};
      2'd1: e = o[2] ? {{48{v[15]}}, v[15:0]} : {48'b0, v[15:0]};
      2'd2: e = o[2] ? {{32{v[31]}}, v[31:0]} : {32'b0, v[31:0]};
      default: e = v;
    endcase
    e = e << s;
    return w ? e : {32'b0, e[31:0]};
  endfunction

  task automatic alu_model(input logic [63:0] a, input logic [63:0] b, input logic w,
                           input logic s, output logic [63:0] r, output logic [3:0] f);
    logic [66:0] ua, ub, ue;
    logic signed [66:0] sa, sb, se, lim;
    if (w) begin
      ua = {3'b0, a}; ub = {3'b0, b};
      sa = {{3{a[63]}}, a}; sb = {{3{b[63]}}, b};
      lim = 67'sd1 <<< 63;
    end else begin
      ua = {35'b0, a[31:0]}; ub = {35'b0, b[31:0]};
      sa = {{35{a[31]}}, a[31:0]}; sb = {{35{b[31]}}, b[31:0]};
      lim = 67'sd1 <<< 31;
    end
    ue = s ? ua - ub : ua + ub;
    se = s ? sa - sb : sa + sb;
    r  = w ? ue[63:0] : {32'b0, ue[31:0]};
    f[3] = w ? r[63] : r[31];
    f[2] = (r == 64'd0);
    f[1] = s ? (ua >= ub) : (w ? ue[64] : ue[32]);
    f[0] = (se >= lim) || (se < -lim);
  endtask

  // Drives one vector, checks it one edge later.
  task automatic run(input string tag, input logic [4:0] ni, input logic [63:0] nv,
                     input logic [63:0] spv, input logic [4:0] mi, input logic [63:0] mv,
                     input logic [4:0] di, input logic [2:0] o, input logic [2:0] s,
                     input logic w, input logic sb, input logic sf);
    logic [63:0] a, b, r;
    logic [3:0] f;
    @(negedge clk);
    rn_idx = ni; rn_val = nv; sp_val = spv; rm_idx = mi; rm_val = mv; rd_idx = di;
    ext_opt = o; shamt = s; wide = w; is_sub = sb; set_flags = sf;
    a = (ni == 5'd31) ? spv : nv;
    b = ext_model((mi == 5'd31) ? 64'd0 : mv, o, s, w);
    alu_model(a, b, w, sb, r, f);
    if (s > 3'd4) begin
      r = '0;
      exp_fl = '0;
    end else if (sf) begin
      exp_fl = f;
    end
    @(posedge clk);
    #1;
    chk({tag, " result"}, result, r);
    chk({tag, " nzcv"}, {60'b0, nzcv}, {60'b0, exp_fl});
    chk({tag, " illegal"}, {63'b0, illegal}, {63'b0, (s > 3'd4)});
    chk({tag, " wr_sp"}, {63'b0, wr_sp}, {63'b0, (di == 5'd31)});
  endtask

  function automatic string tag_of(input logic [2:0] o, input logic [2:0] s,
                                   input logic w, input logic sb);
    if (s > 3'd4) return "R5";
    if (o[1:0] == 2'd3) return "R2";
    if (!w) return "R6";
    if (sb) return "R7";
    return "R1";
  endfunction

  initial begin
    logic [63:0] rmv [6];
    logic [63:0] rnv [3];
    logic [63:0] held;
    int k;
    rmv[0] = 64'h0; rmv[1] = '1; rmv[2] = 64'h8000_0000_0000_0080;
    rmv[3] = 64'h1234_5678_9ABC_DEF0; rmv[4] = 64'h0000_0000_8000_8000;
    rmv[5] = 64'h7FFF_FFFF_FFFF_FF7F;
    rnv[0] = 64'h0; rnv[1] = 64'h7FFF_FFFF_7FFF_FFFF; rnv[2] = 64'hFFFF_FFFF_FFFF_FFF0;

    repeat (2) @(posedge clk);
    #1;
    // R10: reset state
    chk("R10 result", result, 64'd0);
    chk("R10 nzcv", {60'b0, nzcv}, 64'd0);
    chk("R10 wr_sp", {63'b0, wr_sp}, 64'd0);
    chk("R10 illegal", {63'b0, illegal}, 64'd0);
    @(negedge clk);
    rst = 1'b0;

    // R3: shift of a single bit through 0..4
    for (int s = 0; s <= 4; s++)
      run("R3", 5'd3, 64'd100, 64'd0, 5'd4, 64'h101, 5'd7, 3'd0, 3'(s), 1'b1, 1'b0, 1'b1);

    // R4: word and doubleword options match a plain shift on 32-bit
    for (int i = 0; i < 4; i++) begin
      logic [2:0] o;
      logic [63:0] r;
      logic [3:0] f;
      o = (i == 0) ? 3'd2 : (i == 1) ? 3'd3 : (i == 2) ? 3'd6 : 3'd7;
      run("R4", 5'd3, 64'h1_FFFF_FFF0, 64'd0, 5'd4, 64'hABCD_0000_9000_0003, 5'd7,
          o, 3'd3, 1'b0, 1'b0, 1'b1);
      alu_model(64'h1_FFFF_FFF0, {32'b0, 32'h9000_0003 << 3}, 1'b0, 1'b0, r, f);
      chk("R4 lsl result", result, r);
      chk("R4 lsl flags", {60'b0, nzcv}, {60'b0, f});
    end

    // R9: index 31 mapping
    run("R9 rn31", 5'd31, 64'hDEAD, 64'h4000, 5'd4, 64'h10, 5'd31, 3'd3, 3'd0, 1'b1, 1'b0, 1'b0);
    chk("R9 rn31 sp", result, 64'h4010);
    run("R9 rm31", 5'd3, 64'h55, 64'h0, 5'd31, 64'hFFFF, 5'd2, 3'd3, 3'd2, 1'b1, 1'b0, 1'b0);
    chk("R9 rm31 zero", result, 64'h55);

    // R8: flags held when not enabled
    run("R8 set", 5'd3, 64'd5, 64'd0, 5'd4, 64'd5, 5'd7, 3'd3, 3'd0, 1'b1, 1'b1, 1'b1);
    chk("R8 zero flag", {60'b0, nzcv}, 64'h6);
    run("R8 hold", 5'd3, 64'd1, 64'd0, 5'd4, 64'd5, 5'd7, 3'd3, 3'd0, 1'b1, 1'b1, 1'b0);
    chk("R8 held", {60'b0, nzcv}, 64'h6);

    // R11: output only changes at the edge
    held = result;
    @(negedge clk);
    rm_val = 64'h77; ext_opt = 3'd3; shamt = 3'd0; set_flags = 1'b0; is_sub = 1'b0;
    #1;
    chk("R11 before edge", result, held);
    @(posedge clk);
    #1;
    chk("R11 after edge", result, 64'h78);

    // Near-exhaustive sweep
    k = 0;
    for (int o = 0; o < 8; o++)
      for (int s = 0; s < 8; s++)
        for (int w = 0; w < 2; w++)
          for (int sb = 0; sb < 2; sb++)
            for (int m = 0; m < 6; m++)
              for (int n = 0; n < 3; n++) begin
                k++;
                run(tag_of(3'(o), 3'(s), w[0], sb[0]), 5'd3, rnv[n], 64'd0, 5'd4, rmv[m],
                    (k % 5 == 0) ? 5'd31 : 5'd7, 3'(o), 3'(s), w[0], sb[0], (k % 3 != 0));
              end

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule